// File: doc/BRIEF.md
# Response Packet Legality Checker

This block sits behind the packet parser on a RapidIO-style link. It judges every decoded response that comes back for an outstanding read request or write-with-response request. The issuing side records each request in a small table as it goes out. The table is indexed directly by transaction ID and holds the request kind and the expected number of payload beats. When a response header strobe arrives, the block finds the entry for the target ID. It applies the completion-status rules and the per-kind payload rules. It then gives one verdict for that response, one cycle later.

A legal response is passed on with its ID and status. An illegal one raises a one-cycle error strobe with a cause mask. The first illegal response also fills a set of capture registers, which hold their contents until a clear request. Any response that matches an entry frees that entry, whether the response is legal or not, so the table cannot leak.

The header encodings are fixed:
- Status DONE is 4'b0000 and ERROR is 4'b0111.
- Transaction type 4'b0000 means a response without data, and 4'b1000 means a response with data.
- On a request, `req_write`=0 marks a read and `req_write`=1 marks a write-with-response.

Payload length is counted in beats of `BEAT_BYTES` bytes.

Top module: `rsp_legality_chk`

## Requirements
- R1: After reset, every output is 0 and the table holds no entry, so the first response to any ID is flagged as unmatched (cause bit 1).
- R2: A response whose status is neither 4'b0000 nor 4'b0111 is illegal and sets cause bit 0.
- R3: A response whose ID has no outstanding entry is illegal and sets cause bit 1. In that case, no payload rule (bits 2, 3, 4) is applied.
- R4: A response to a write-with-response entry is illegal and sets cause bit 2 when it carries one or more payload beats or its type is 4'b1000.
- R5: A response to a read entry is illegal and sets cause bit 3 when it carries zero beats or its type is 4'b0000.
- R6: A response to a read entry with a nonzero beat count is illegal and sets cause bit 4 when that count differs from ceil(requested bytes / `BEAT_BYTES`).
- R7: With `STRICT_TYPE`=1, a type other than 4'b0000 and 4'b1000 is illegal and sets cause bit 5.
- R8: In the cycle after each response strobe, exactly one of `ok_valid` or `err_pulse` is high for one cycle:
  - `err_pulse` goes high with the cause mask in `err_cause` when any cause bit is set.
  - Otherwise `ok_valid` goes high with the response ID and status.
  - With no strobe, both stay low.
- R9: The first illegal response while `cap_valid` is 0 latches ID, type, status and cause, and sets `cap_valid`. These are held through later errors until `cap_clear`. If a clear and an error come in the same cycle, the new error is captured.
- R10: A response that matches an entry frees it whether it is legal or illegal, so a repeated response to that ID is flagged as unmatched.
- R11: When a request and a response for the same ID come in the same cycle, the response is judged against the old entry, and the entry is then left holding the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Record an outstanding request |
| req_tid | input | TID_W | ID of the recorded request |
| req_write | input | 1 | 1 = write-with-response, 0 = read |
| req_bytes | input | BYTES_W | Requested read size in bytes |
| rsp_valid | input | 1 | Response header strobe |
| rsp_tid | input | TID_W | Target transaction ID of the response |
| rsp_ttype | input | 4 | Response transaction type |
| rsp_status | input | 4 | Response status field |
| rsp_beats | input | BEAT_W | Payload beats received |
| cap_clear | input | 1 | Clear the capture valid bit |
| ok_valid | output | 1 | Legal response passed on |
| ok_tid | output | TID_W | ID of the passed response |
| ok_status | output | 4 | Status of the passed response |
| err_pulse | output | 1 | One-cycle illegal-response strobe |
| err_cause | output | CAUSE_W | Violation mask for the strobed response |
| cap_valid | output | 1 | Capture registers hold an error |
| cap_tid | output | TID_W | Captured ID |
| cap_ttype | output | 4 | Captured transaction type |
| cap_status | output | 4 | Captured status |
| cap_cause | output | CAUSE_W | Captured cause mask |

## Verification
The bench builds the block with its defaults:
- `TID_W`=4, which gives a 16-entry table.
- `BEAT_BYTES`=8 and `MAX_BYTES`=256, so the beat counts run from 1 to 32 and the field is 6 bits wide.
- `STRICT_TYPE`=1.

With only 16 IDs, random traffic often reaches both live and free entries, and it also overwrites entries. Byte sizes that are not multiples of 8 exercise the round-up used for the expected beat count. Beat counts up to 40 probe sizes just past the largest request. The strict setting puts the unknown-type rule within reach, next to the payload and status rules.

// File: rtl/rspchk_pkg.sv
package rspchk_pkg;
   localparam logic [3:0] ST_DONE   = 4'b0000;
   localparam logic [3:0] ST_ERROR  = 4'b0111;
   localparam logic [3:0] TT_NODATA = 4'b0000;
   localparam logic [3:0] TT_DATA   = 4'b1000;

   localparam int CAUSE_W   = 6;
   localparam int CB_STATUS = 0;
   localparam int CB_NOHIT  = 1;
   localparam int CB_WRDATA = 2;
   localparam int CB_RDNONE = 3;
   localparam int CB_RDSIZE = 4;
   localparam int CB_TYPE   = 5;

   typedef logic [CAUSE_W-1:0] cause_t;

   typedef enum logic {
      KIND_READ  = 1'b0,
      KIND_WRITE = 1'b1
   } req_kind_e;
endpackage

// File: rtl/rsp_table.sv
module rsp_table
   import rspchk_pkg::*;
#(
   parameter int TID_W  = 4,
   parameter int BEAT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [TID_W-1:0]  alloc_tid,
   input  req_kind_e         alloc_kind,
   input  logic [BEAT_W-1:0] alloc_beats,
   input  logic              free_en,
   input  logic [TID_W-1:0]  free_tid,
   input  logic [TID_W-1:0]  look_tid,
   output logic              look_hit,
   output req_kind_e         look_kind,
   output logic [BEAT_W-1:0] look_beats
);
   localparam int ENTRIES = 1 << TID_W;

   logic              busy_a  [ENTRIES];
   req_kind_e         kind_a  [ENTRIES];
   logic [BEAT_W-1:0] beats_a [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic              busy_q;
      req_kind_e         kind_q;
      logic [BEAT_W-1:0] beats_q;
      logic              sel_alloc;
      logic              sel_free;

      assign sel_alloc = alloc_en && (alloc_tid == TID_W'(i));
      assign sel_free  = free_en  && (free_tid  == TID_W'(i));

      // allocation wins over a same-cycle free of the same entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_q  <= 1'b0;
            kind_q  <= KIND_READ;
            beats_q <= '0;
         end else if (sel_alloc) begin
            busy_q  <= 1'b1;
            kind_q  <= alloc_kind;
            beats_q <= alloc_beats;
         end else if (sel_free) begin
            busy_q  <= 1'b0;
         end
      end

      assign busy_a[i]  = busy_q;
      assign kind_a[i]  = kind_q;
      assign beats_a[i] = beats_q;
   end

   assign look_hit   = busy_a[look_tid];
   assign look_kind  = kind_a[look_tid];
   assign look_beats = beats_a[look_tid];
endmodule

// File: rtl/rsp_rules.sv
module rsp_rules
   import rspchk_pkg::*;
#(
   parameter int BEAT_W      = 6,
   parameter bit STRICT_TYPE = 1'b1
) (
   input  logic              hit,
   input  req_kind_e         kind,
   input  logic [BEAT_W-1:0] exp_beats,
   input  logic [3:0]        ttype,
   input  logic [3:0]        status,
   input  logic [BEAT_W-1:0] beats,
   output cause_t            cause
);
   logic has_beats;
   logic is_rd;
   logic is_wr;
   logic type_bad;

   assign has_beats = (beats != '0);
   assign is_rd     = hit && (kind == KIND_READ);
   assign is_wr     = hit && (kind == KIND_WRITE);

   if (STRICT_TYPE) begin : g_strict
      assign type_bad = (ttype != TT_NODATA) && (ttype != TT_DATA);
   end else begin : g_lax
      assign type_bad = 1'b0;
   end

   always_comb begin
      cause            = '0;
      cause[CB_STATUS] = (status != ST_DONE) && (status != ST_ERROR);
      cause[CB_NOHIT]  = !hit;
      cause[CB_WRDATA] = is_wr && (has_beats || (ttype == TT_DATA));
      cause[CB_RDNONE] = is_rd && (!has_beats || (ttype == TT_NODATA));
      cause[CB_RDSIZE] = is_rd && has_beats && (beats != exp_beats);
      cause[CB_TYPE]   = type_bad;
   end
endmodule

// File: rtl/err_capture.sv
module err_capture
   import rspchk_pkg::*;
#(
   parameter int TID_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt,
   input  logic             clr,
   input  logic [TID_W-1:0] tid,
   input  logic [3:0]       ttype,
   input  logic [3:0]       status,
   input  cause_t           cause,
   output logic             cap_valid,
   output logic [TID_W-1:0] cap_tid,
   output logic [3:0]       cap_ttype,
   output logic [3:0]       cap_status,
   output cause_t           cap_cause
);
   logic take;

   assign take = evt && (!cap_valid || clr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_valid  <= 1'b0;
         cap_tid    <= '0;
         cap_ttype  <= '0;
         cap_status <= '0;
         cap_cause  <= '0;
      end else begin
         if (clr) cap_valid <= 1'b0;
         if (take) begin
            cap_valid  <= 1'b1;
            cap_tid    <= tid;
            cap_ttype  <= ttype;
            cap_status <= status;
            cap_cause  <= cause;
         end
      end
   end
endmodule

// File: rtl/rsp_legality_chk.sv
module rsp_legality_chk
   import rspchk_pkg::*;
#(
   parameter int TID_W       = 4,
   parameter int BEAT_BYTES  = 8,
   parameter int MAX_BYTES   = 256,
   parameter bit STRICT_TYPE = 1'b1,
   localparam int BYTES_W    = $clog2(MAX_BYTES + 1),
   localparam int BEAT_W     = $clog2(MAX_BYTES / BEAT_BYTES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [TID_W-1:0]    req_tid,
   input  logic                req_write,
   input  logic [BYTES_W-1:0]  req_bytes,
   input  logic                rsp_valid,
   input  logic [TID_W-1:0]    rsp_tid,
   input  logic [3:0]          rsp_ttype,
   input  logic [3:0]          rsp_status,
   input  logic [BEAT_W-1:0]   rsp_beats,
   input  logic                cap_clear,
   output logic                ok_valid,
   output logic [TID_W-1:0]    ok_tid,
   output logic [3:0]          ok_status,
   output logic                err_pulse,
   output logic [CAUSE_W-1:0]  err_cause,
   output logic                cap_valid,
   output logic [TID_W-1:0]    cap_tid,
   output logic [3:0]          cap_ttype,
   output logic [3:0]          cap_status,
   output logic [CAUSE_W-1:0]  cap_cause
);
   localparam int BEAT_SH = $clog2(BEAT_BYTES);

   if ((1 << BEAT_SH) != BEAT_BYTES) begin : g_chk_beat
      $error("BEAT_BYTES must be a power of two");
   end
   if (TID_W < 1 || TID_W > 8) begin : g_chk_tid
      $error("TID_W must lie in 1..8");
   end
   if (MAX_BYTES < BEAT_BYTES || (MAX_BYTES % BEAT_BYTES) != 0) begin : g_chk_max
      $error("MAX_BYTES must be a nonzero multiple of BEAT_BYTES");
   end

   logic [BYTES_W:0]  rnd_sum;
   logic [BEAT_W-1:0] req_beats;
   logic              look_hit;
   req_kind_e         look_kind;
   logic [BEAT_W-1:0] look_beats;
   cause_t            cause;
   logic              bad;

   assign rnd_sum   = {1'b0, req_bytes} + (BYTES_W + 1)'(BEAT_BYTES - 1);
   assign req_beats = BEAT_W'(rnd_sum >> BEAT_SH);

   rsp_table #(.TID_W(TID_W), .BEAT_W(BEAT_W)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_en   (req_valid),
      .alloc_tid  (req_tid),
      .alloc_kind (req_write ? KIND_WRITE : KIND_READ),
      .alloc_beats(req_beats),
      .free_en    (rsp_valid && look_hit),
      .free_tid   (rsp_tid),
      .look_tid   (rsp_tid),
      .look_hit   (look_hit),
      .look_kind  (look_kind),
      .look_beats (look_beats)
   );

   rsp_rules #(.BEAT_W(BEAT_W), .STRICT_TYPE(STRICT_TYPE)) u_rules (
      .hit      (look_hit),
      .kind     (look_kind),
      .exp_beats(look_beats),
      .ttype    (rsp_ttype),
      .status   (rsp_status),
      .beats    (rsp_beats),
      .cause    (cause)
   );

   assign bad = (cause != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ok_valid  <= 1'b0;
         ok_tid    <= '0;
         ok_status <= '0;
         err_pulse <= 1'b0;
         err_cause <= '0;
      end else begin
         ok_valid  <= rsp_valid && !bad;
         err_pulse <= rsp_valid && bad;
         err_cause <= (rsp_valid && bad) ? cause : '0;
         if (rsp_valid) begin
            ok_tid    <= rsp_tid;
            ok_status <= rsp_status;
         end
      end
   end

   err_capture #(.TID_W(TID_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (rsp_valid && bad),
      .clr       (cap_clear),
      .tid       (rsp_tid),
      .ttype     (rsp_ttype),
      .status    (rsp_status),
      .cause     (cause),
      .cap_valid (cap_valid),
      .cap_tid   (cap_tid),
      .cap_ttype (cap_ttype),
      .cap_status(cap_status),
      .cap_cause (cap_cause)
   );
endmodule

// File: rtl/rspchk_sva.sv
module rspchk_sva
   import rspchk_pkg::*;
#(
   parameter int TID_W       = 4,
   parameter bit STRICT_TYPE = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rsp_valid,
   input logic [3:0]         rsp_ttype,
   input logic [3:0]         rsp_status,
   input logic               cap_clear,
   input logic               ok_valid,
   input logic [3:0]         ok_status,
   input logic               err_pulse,
   input logic [CAUSE_W-1:0] err_cause,
   input logic               cap_valid,
   input logic [TID_W-1:0]   cap_tid,
   input logic [CAUSE_W-1:0] cap_cause
);
   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(ok_valid && err_pulse));

   a_r8_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (ok_valid || err_pulse) |-> $past(rsp_valid));

   a_r8_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (err_cause != '0));

   a_r2_status: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status != ST_DONE && rsp_status != ST_ERROR)
      |=> (err_pulse && err_cause[CB_STATUS]));

   a_r2_ok_status: assert property (@(posedge clk) disable iff (!rst_n)
      ok_valid |-> (ok_status == ST_DONE || ok_status == ST_ERROR));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_valid && !cap_clear) |=> (cap_valid && $stable(cap_tid) && $stable(cap_cause)));

   a_r9_filled: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> cap_valid);

   if (STRICT_TYPE) begin : g_type
      a_r7_type: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && rsp_ttype != TT_NODATA && rsp_ttype != TT_DATA)
         |=> (err_pulse && err_cause[CB_TYPE]));
   end
endmodule

bind rsp_legality_chk rspchk_sva #(.TID_W(TID_W), .STRICT_TYPE(STRICT_TYPE)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .rsp_valid (rsp_valid),
   .rsp_ttype (rsp_ttype),
   .rsp_status(rsp_status),
   .cap_clear (cap_clear),
   .ok_valid  (ok_valid),
   .ok_status (ok_status),
   .err_pulse (err_pulse),
   .err_cause (err_cause),
   .cap_valid (cap_valid),
   .cap_tid   (cap_tid),
   .cap_cause (cap_cause)
);

// File: tb/sim_rsp_legality_chk.sv
`timescale 1ns/1ps
module sim_rsp_legality_chk;
   localparam int TW = 4;
   localparam int BW = 6;
   localparam int YW = 9;
   localparam int CW = 6;
   localparam int BB = 8;
   localparam int NE = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, rsp_valid = 1'b0, cap_clear = 1'b0;
   logic [TW-1:0] req_tid = '0, rsp_tid = '0;
   logic [YW-1:0] req_bytes = '0;
   logic [3:0] rsp_ttype = '0, rsp_status = '0;
   logic [BW-1:0] rsp_beats = '0;
   logic ok_valid, err_pulse, cap_valid;
   logic [TW-1:0] ok_tid, cap_tid;
   logic [3:0] ok_status, cap_ttype, cap_status;
   logic [CW-1:0] err_cause, cap_cause;

   always #4 clk = ~clk;

   rsp_legality_chk u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
      .req_write(req_write), .req_bytes(req_bytes), .rsp_valid(rsp_valid),
      .rsp_tid(rsp_tid), .rsp_ttype(rsp_ttype), .rsp_status(rsp_status),
      .rsp_beats(rsp_beats), .cap_clear(cap_clear), .ok_valid(ok_valid),
      .ok_tid(ok_tid), .ok_status(ok_status), .err_pulse(err_pulse),
      .err_cause(err_cause), .cap_valid(cap_valid), .cap_tid(cap_tid),
      .cap_ttype(cap_ttype), .cap_status(cap_status), .cap_cause(cap_cause)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   bit          m_busy [NE];
   bit          m_wr   [NE];
   int          m_eb   [NE];
   bit          mc_v = 1'b0;
   logic [3:0]  mc_tid = '0;
   logic [CW-1:0] mc_cause = '0;
   logic [CW-1:0] last_exp = '0;

   task automatic check(input bit good, input string req, input int act, input int exp);
      n_tests++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int beats_of(input int bytes);
      return (bytes + BB - 1) / BB;
   endfunction

   function automatic logic [CW-1:0] exp_cause(input bit hit, input bit wr, input int eb,
                                               input int tt, input int st, input int b);
      logic [CW-1:0] c = '0;
      c[0] = (st != 0) && (st != 7);
      c[1] = !hit;
      c[2] = hit && wr && (b != 0 || tt == 8);
      c[3] = hit && !wr && (b == 0 || tt == 0);
      c[4] = hit && !wr && b != 0 && b != eb;
      c[5] = (tt != 0) && (tt != 8);
      return c;
   endfunction

   task automatic step(input bit rq, input int rqt, input bit rqw, input int rqb,
                       input bit rs, input int rt, input int rtt, input int rss,
                       input int rb, input bit clr);
      logic [CW-1:0] c;
      req_valid  = rq;  req_tid = TW'(rqt); req_write = rqw; req_bytes = YW'(rqb);
      rsp_valid  = rs;  rsp_tid = TW'(rt);  rsp_ttype = 4'(rtt); rsp_status = 4'(rss);
      rsp_beats  = BW'(rb); cap_clear = clr;
      c = exp_cause(m_busy[rt], m_wr[rt], m_eb[rt], rtt, rss, rb);
      last_exp = rs ? c : '0;
      @(negedge clk);
      req_valid = 1'b0; rsp_valid = 1'b0; cap_clear = 1'b0;
      if (rs) begin
         check(err_cause[0] == c[0], "R2 status cause", int'(err_cause), int'(c));
         check(err_cause[1] == c[1], "R3 unmatched cause", int'(err_cause), int'(c));
         check(err_cause[2] == c[2], "R4 write payload cause", int'(err_cause), int'(c));
         check(err_cause[3] == c[3], "R5 read no-payload cause", int'(err_cause), int'(c));
         check(err_cause[4] == c[4], "R6 read size cause", int'(err_cause), int'(c));
         check(err_cause[5] == c[5], "R7 type cause", int'(err_cause), int'(c));
         check(err_pulse == (c != 0), "R8 err_pulse", int'(err_pulse), int'(c != 0));
         check(ok_valid == (c == 0), "R8 ok_valid", int'(ok_valid), int'(c == 0));
         if (c == 0) check(ok_tid == TW'(rt) && ok_status == 4'(rss), "R8 ok fields",
                           int'({ok_tid, ok_status}), (rt << 4) | rss);
      end else begin
         check(!ok_valid && !err_pulse, "R8 idle outputs", int'({ok_valid, err_pulse}), 0);
      end
      // capture model (R9)
      if (rs && c != 0 && (!mc_v || clr)) begin
         mc_v = 1'b1; mc_tid = 4'(rt); mc_cause = c;
      end else if (clr) begin
         mc_v = 1'b0;
      end
      check(cap_valid == mc_v, "R9 cap_valid", int'(cap_valid), int'(mc_v));
      if (mc_v) check(cap_tid == mc_tid && cap_cause == mc_cause, "R9 capture contents",
                      int'({cap_tid, cap_cause}), int'({mc_tid, mc_cause}));
      // table model: free on any matched response (R10), then allocate (R11)
      if (rs && m_busy[rt]) m_busy[rt] = 1'b0;
      if (rq) begin
         m_busy[rqt] = 1'b1; m_wr[rqt] = rqw; m_eb[rqt] = beats_of(rqb);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL R8 watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < NE; i++) begin m_busy[i] = 0; m_wr[i] = 0; m_eb[i] = 0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!ok_valid && !err_pulse && err_cause == 0 && !cap_valid, "R1 reset outputs",
            int'({ok_valid, err_pulse, cap_valid}), 0);
      rst_n = 1'b1;
      step(0, 0, 0, 0, 1, 3, 8, 0, 1, 0);
      check(err_cause[1] == 1'b1, "R1 empty table after reset", int'(err_cause), 2);

      // directed: legal read, 20 bytes -> 3 beats
      step(1, 5, 0, 20, 0, 0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 1, 5, 8, 0, 3, 0);
      // R10: repeat response is unmatched
      step(0, 0, 0, 0, 1, 5, 8, 0, 3, 0);
      check(err_cause == 6'b000010, "R10 freed entry", int'(err_cause), 2);
      // R10: illegal response also frees
      step(1, 6, 1, 0, 0, 0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 1, 6, 8, 7, 2, 0);
      check(err_cause == 6'b000100, "R4 write with data", int'(err_cause), 4);
      step(0, 0, 0, 0, 1, 6, 0, 0, 0, 0);
      check(err_cause == 6'b000010, "R10 freed after illegal", int'(err_cause), 2);
      // R11: same-cycle response and new request for one ID
      step(1, 9, 1, 0, 0, 0, 0, 0, 0, 1);
      step(1, 9, 0, 16, 1, 9, 0, 0, 0, 0);
      check(ok_valid == 1'b1, "R11 judged on old entry", int'(ok_valid), 1);
      step(0, 0, 0, 0, 1, 9, 8, 7, 2, 0);
      check(ok_valid == 1'b1, "R11 new entry kept", int'(ok_valid), 1);
      // R6 boundary: 256 bytes -> 32 beats; 33 beats wrong
      step(1, 15, 0, 256, 0, 0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 1, 15, 8, 0, 33, 0);
      check(err_cause == 6'b010000, "R6 oversize read", int'(err_cause), 16);
      // R5 read with no beats and type without data
      step(1, 2, 0, 8, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 2, 0, 0, 0, 0);
      check(err_cause == 6'b001000, "R5 read without payload", int'(err_cause), 8);
      // R9: clear and new error in same cycle
      step(0, 0, 0, 0, 1, 11, 3, 2, 0, 1);
      check(cap_tid == 4'd11, "R9 capture on clear", int'(cap_tid), 11);

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         bit do_rq, do_rs, w, clr;
         int t, b, rt, tt, st, rb;
         do_rq = ($urandom_range(0, 99) < 45);
         do_rs = !do_rq || ($urandom_range(0, 99) < 10);
         t  = $urandom_range(0, NE - 1);
         w  = $urandom_range(0, 1);
         b  = $urandom_range(1, 256);
         rt = $urandom_range(0, NE - 1);
         if (m_busy[rt] && m_wr[rt]) begin tt = 0; rb = 0; end
         else begin tt = 8; rb = m_busy[rt] ? m_eb[rt] : 1; end
         st = ($urandom_range(0, 1) != 0) ? 7 : 0;
         if ($urandom_range(0, 99) < 12) tt = $urandom_range(0, 15);
         if ($urandom_range(0, 99) < 12) rb = $urandom_range(0, 40);
         if ($urandom_range(0, 99) < 8)  st = $urandom_range(0, 15);
         clr = ($urandom_range(0, 99) < 10);
         step(do_rq, t, w, b, do_rs, rt, tt, st, rb, clr);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule